// File: doc/BRIEF.md
# Binary Content Addressable Memory

This block is a small binary content addressable memory: a table of rows that is looked up by content rather than by address. A single active-low mode pin chooses each cycle between storing a word and searching for one. When the pin is low, the write data is placed into the row named by the write address. When the pin is high, the search word is compared against every stored row in parallel. The block then reports whether any row holds that word and, if one does, where it is.

The match address is built by plain OR gates over the per-row hit lines, with no priority encoder. Output bit k is high when any hitting row has bit k set in its index. A single hit therefore gives that row's index, and several hits give the bitwise OR of their indices. The found flag and the match address are registered and stay steady for a full clock cycle. The rows have no valid bit and are not cleared by reset, so a user writes every row before relying on search results.

Top module: `cam_binary_top`

## Requirements
- R1: A cycle with `rst` high clears both registered outputs: `found` is 0 and `match_addr` is 0 after that clock edge.
- R2: With `wr_n` low at a rising edge, `wr_data` is stored in row `wr_addr`, where row indices run from 0 to ROWS-1.
- R3: With `wr_n` high at a rising edge, `found` is 1 after that edge exactly when some stored row equals `search_word`. The result appears one cycle after the search inputs are sampled.
- R4: When a search hits no row, `found` is 0 and `match_addr` is 0 after the edge.
- R5: `match_addr` bit k after a search is the OR, over every row whose content equals `search_word`, of bit k of that row's index. A single hit gives the row index, and hits in rows 3 and 5 give 7.
- R6: After an edge with `wr_n` low, no search is done: `found` is 0 and `match_addr` is 0.
- R7: A search in the cycle right after a write sees the newly written word.
- R8: A write changes only the addressed row. Every other row keeps its content, and the overwritten word is no longer found in that row.
- R9: A search does not change any stored row. Repeating a search with no write in between gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| wr_n | input | 1 | Mode: 0 = write, 1 = search |
| wr_addr | input | AW (3) | Row written when `wr_n` is 0 |
| wr_data | input | WIDTH (8) | Word stored when `wr_n` is 0 |
| search_word | input | WIDTH (8) | Word compared against all rows when `wr_n` is 1 |
| match_addr | output | AW (3) | Registered OR-encoded index of the hitting rows |
| found | output | 1 | Registered flag: at least one row hit |

## Verification
The hardest case to reach from the ports is several rows holding the same word at once, because only then does the OR encoding differ from a priority encoder. The bench first loads all rows with distinct words and sweeps every possible search word. It then copies one word into chosen pairs and triples of rows and searches again, checking that the address is the OR of their indices. It also searches immediately after each overwrite, to catch stale data and lost neighbouring rows.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned CAM_ROWS_DEF  = 8;
  localparam int unsigned CAM_WIDTH_DEF = 8;

  typedef enum logic {
    MODE_WRITE  = 1'b0,
    MODE_SEARCH = 1'b1
  } cam_mode_e;
endpackage

// File: rtl/cam_row_store.sv
module cam_row_store #(
  parameter int unsigned ROWS  = cam_pkg::CAM_ROWS_DEF,
  parameter int unsigned WIDTH = cam_pkg::CAM_WIDTH_DEF,
  localparam int unsigned AW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [ROWS-1:0][WIDTH-1:0]  rows_q
);
  logic [ROWS-1:0] row_sel;

  // one-hot write decode, one select line per row
  for (genvar r = 0; r < ROWS; r++) begin : g_dec
    assign row_sel[r] = we && (wr_addr == AW'(r));

    always_ff @(posedge clk) begin
      if (row_sel[r]) rows_q[r] <= wr_data;
    end
  end
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
  parameter int unsigned ROWS  = cam_pkg::CAM_ROWS_DEF,
  parameter int unsigned WIDTH = cam_pkg::CAM_WIDTH_DEF
) (
  input  logic [ROWS-1:0][WIDTH-1:0] rows_q,
  input  logic [WIDTH-1:0]           key,
  output logic [ROWS-1:0]            hit
);
  for (genvar r = 0; r < ROWS; r++) begin : g_cmp
    assign hit[r] = (rows_q[r] == key);
  end
endmodule

// File: rtl/cam_or_encoder.sv
module cam_or_encoder #(
  parameter int unsigned ROWS = cam_pkg::CAM_ROWS_DEF,
  localparam int unsigned AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0] hit,
  output logic [AW-1:0]   addr,
  output logic            any
);
  // bit k: OR of hit lines whose row index has bit k set
  for (genvar k = 0; k < AW; k++) begin : g_bit
    logic [ROWS-1:0] sel_mask;
    for (genvar r = 0; r < ROWS; r++) begin : g_m
      assign sel_mask[r] = ((r >> k) & 1) != 0;
    end
    assign addr[k] = |(hit & sel_mask);
  end
  assign any = |hit;
endmodule

// File: rtl/cam_binary_top.sv
module cam_binary_top #(
  parameter int unsigned ROWS  = cam_pkg::CAM_ROWS_DEF,
  parameter int unsigned WIDTH = cam_pkg::CAM_WIDTH_DEF,
  localparam int unsigned AW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] search_word,
  output logic [AW-1:0]    match_addr,
  output logic             found
);
  import cam_pkg::*;

  cam_mode_e                       mode;
  logic [ROWS-1:0][WIDTH-1:0]      rows_q;
  logic [ROWS-1:0]                 hit;
  logic [AW-1:0]                   enc_addr;
  logic                            enc_any;

  assign mode = cam_mode_e'(wr_n);

  cam_row_store #(.ROWS(ROWS), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .we      (mode == MODE_WRITE),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rows_q  (rows_q)
  );

  cam_match_array #(.ROWS(ROWS), .WIDTH(WIDTH)) u_match (
    .rows_q (rows_q),
    .key    (search_word),
    .hit    (hit)
  );

  cam_or_encoder #(.ROWS(ROWS)) u_enc (
    .hit  (hit),
    .addr (enc_addr),
    .any  (enc_any)
  );

  always_ff @(posedge clk) begin
    if (rst || mode == MODE_WRITE) begin
      match_addr <= '0;
      found      <= 1'b0;
    end else begin
      match_addr <= enc_addr;
      found      <= enc_any;
    end
  end
endmodule

// File: rtl/cam_binary_chk.sv
module cam_binary_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_n,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] search_word,
  input logic [AW-1:0]    match_addr,
  input logic             found
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  logic settled;
  assign settled = (age >= 2'd2);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!found && match_addr == '0));

  p_write_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> (!found && match_addr == '0));

  p_miss_zero_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (settled && !found) |-> (match_addr == '0));

  p_addr_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (settled && match_addr != '0) |-> found);

  p_fresh_write_seen_r7: assert property (@(posedge clk) disable iff (rst)
    (settled && wr_n && !$past(wr_n) && search_word == $past(wr_data)) |=> found);

  p_repeat_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (settled && wr_n && $past(wr_n) && search_word == $past(search_word))
      |=> ($stable(found) && $stable(match_addr)));
endmodule

bind cam_binary_top cam_binary_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_n        (wr_n),
  .wr_data     (wr_data),
  .search_word (search_word),
  .match_addr  (match_addr),
  .found       (found)
);

// File: tb/tb_cam_binary_top.sv
module tb_cam_binary_top;
  localparam int ROWS = 8;
  localparam int WIDTH = 8;
  localparam int AW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0;
  logic rst, wr_n;
  logic [AW-1:0] wr_addr;
  logic [WIDTH-1:0] wr_data, search_word;
  logic [AW-1:0] match_addr;
  logic found;

  int checks = 0, fails = 0;
  logic [WIDTH-1:0] model [ROWS];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_binary_top #(.ROWS(ROWS), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .search_word(search_word), .match_addr(match_addr), .found(found)
  );

  task automatic check(input string req, input logic [AW-1:0] exp_a, input logic exp_f);
    checks++;
    if (match_addr !== exp_a || found !== exp_f) begin
      fails++;
      $display("FAIL %s: actual addr=%0d found=%0b expected addr=%0d found=%0b",
               req, match_addr, found, exp_a, exp_f);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic do_write(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    wr_n = 0; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    model[a] = d;
    check("R6", '0, 1'b0);
  endtask

  task automatic do_search(input logic [WIDTH-1:0] s, input string req);
    logic [AW-1:0] ea;
    logic ef;
    ea = '0; ef = 0;
    for (int r = 0; r < ROWS; r++)
      if (model[r] == s) begin ef = 1; ea = ea | AW'(r); end
    wr_n = 1; search_word = s;
    @(posedge clk); @(negedge clk);
    check(req, ea, ef);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_n = 1; wr_addr = 0; wr_data = 0; search_word = 0;
    @(negedge clk); @(posedge clk); @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst = 0;

    // R2: fill every row with distinct words
    for (int r = 0; r < ROWS; r++) do_write(AW'(r), WIDTH'(r * 37 + 11));
    // R3/R4/R5 sweep of all search words (single-hit and miss)
    for (int s = 0; s < (1 << WIDTH); s++) do_search(WIDTH'(s), "R3/R4/R5 sweep");
    // R9: repeat searches leave contents intact
    for (int r = 0; r < ROWS; r++) begin
      do_search(model[r], "R9 repeat");
      do_search(model[r], "R9 repeat");
    end
    // R7/R8: overwrite then search at once; old word gone, neighbours kept
    for (int r = 0; r < ROWS; r++) begin
      logic [WIDTH-1:0] old;
      old = model[r];
      do_write(AW'(r), WIDTH'(200 + r));
      do_search(WIDTH'(200 + r), "R7 fresh write");
      do_search(old, "R8 old word gone");
      for (int q = 0; q < ROWS; q++) do_search(model[q], "R8 neighbours kept");
    end
    // R5: duplicates, hits in rows 3 and 5 give 7
    do_write(3'd3, 8'hA5);
    do_write(3'd5, 8'hA5);
    wr_n = 1; search_word = 8'hA5;
    @(posedge clk); @(negedge clk);
    check("R5 rows 3+5", 3'd7, 1'b1);
    // R5: every pair of rows holding one word
    for (int a = 0; a < ROWS; a++)
      for (int b = a + 1; b < ROWS; b++) begin
        for (int r = 0; r < ROWS; r++) do_write(AW'(r), WIDTH'(r + 1));
        do_write(AW'(a), 8'hEE);
        do_write(AW'(b), 8'hEE);
        do_search(8'hEE, "R5 pair");
      end
    // R5: a triple
    do_write(3'd1, 8'h3C); do_write(3'd2, 8'h3C); do_write(3'd4, 8'h3C);
    do_search(8'h3C, "R5 triple");
    // R4 miss, then R1 reset again after a hit
    do_search(8'h00, "R4 miss");
    do_search(8'h3C, "R3 hit");
    rst = 1;
    @(posedge clk); @(negedge clk);
    check("R1 reset after hit", '0, 1'b0);
    rst = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule